// File: doc/BRIEF.md
# Dual Counter/Timer with Split Mode

This block holds two 16-bit counter/timers of the classic microcontroller kind, called timer 0 and timer 1. Each one steps either from a shared timebase or from falling edges of its own external count pin. The timebase is the system clock divided by a parameter (twelve by default), or the undivided clock when the timer's fast-clock select is set. Each timer has four modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and mode 3. Every overflow raises a sticky flag that serves as an interrupt request. Timer 1 overflows also emit a one-cycle baud tick.

Putting timer 0 in mode 3 splits it into two 8-bit timers. The low byte keeps timer 0's own controls and flag. The high byte counts only on timer 0's internal timebase, runs under timer 1's run bit, and raises timer 1's flag. While the block is split, timer 1 keeps stepping only to make baud ticks. Its external pin and its flag are taken away, and it is started and stopped by moving it out of and into its own mode 3. A small byte-wide bus reads and writes the four counter bytes and the two flags.

Top module: `dual_timer`

## Requirements
- R1: After reset all four counter bytes, both flags and the baud tick are 0.
- R2: With the fast-clock select at 1, an enabled timer on its internal timebase steps on every clock. With the select at 0, it steps once every PRESCALE (12) clocks on a prescaler shared by both timers.
- R3: With its counter select at 1, a timer steps once for each falling edge of its external pin. The pin passes through a two-flop synchronizer, so the count appears on the third rising clock edge after the pin falls.
- R4: With its gate enable at 0, a timer is enabled by its run bit alone. With the gate enable at 1, it also needs its synchronized gate pin to be high.
- R5: Mode 0 (mode field 0) is a 13-bit counter. Bits 4..0 of the low byte act as a prescale into the high byte, and bits 7..5 of the low byte are left unchanged. The counter overflows when it steps from high byte FF with prescale 31.
- R6: Mode 1 is a 16-bit counter that overflows when it steps from FFFF to 0000.
- R7: Mode 2 steps the low byte only. A step from FF loads the low byte from the high byte and is an overflow.
- R8: With timer 0 in mode 3, the low byte of timer 0 is an 8-bit counter under timer 0's run, gate and counter select. Its wrap from FF to 00 sets flag 0.
- R9: With timer 0 in mode 3, the high byte of timer 0 steps on timer 0's internal timebase whenever timer 1's run bit is 1, whatever the gate or counter settings. Its wrap from FF sets flag 1.
- R10: With timer 0 in mode 3, timer 1 in mode 0, 1 or 2 steps on its internal timebase alone, ignoring its run bit, gate and counter select. Its overflows make baud ticks but never set flag 1.
- R11: Timer 1 in mode 3 holds its count and makes no overflow.
- R12: Bus addresses: 0 is the timer 0 low byte, 1 the timer 0 high byte, 2 the timer 1 low byte, 3 the timer 1 high byte, and 4 the flags (bit 0 flag 0, bit 1 flag 1). Other addresses read 0. A write to a counter byte wins over a step in the same cycle and cancels that timer's step and overflow, except in split mode, where the two timer 0 bytes are independent.
- R13: Flags stay set until written with 0 at address 4. A hardware overflow in the same cycle as such a write leaves the flag set.
- R14: The baud tick is high for the one cycle that follows each timer 1 overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIn0 | input | 1 | Timer 0 external count pin |
| extIn1 | input | 1 | Timer 1 external count pin |
| gateIn0 | input | 1 | Timer 0 gate pin, high enables |
| gateIn1 | input | 1 | Timer 1 gate pin, high enables |
| mode0 | input | 2 | Timer 0 mode |
| ctrSel0 | input | 1 | Timer 0 counts pin edges when 1 |
| gateEn0 | input | 1 | Timer 0 gate enable |
| mode1 | input | 2 | Timer 1 mode |
| ctrSel1 | input | 1 | Timer 1 counts pin edges when 1 |
| gateEn1 | input | 1 | Timer 1 gate enable |
| run0 | input | 1 | Timer 0 run bit |
| run1 | input | 1 | Timer 1 run bit |
| fastClk0 | input | 1 | Timer 0 undivided timebase select |
| fastClk1 | input | 1 | Timer 1 undivided timebase select |
| busWe | input | 1 | Bus write strobe |
| busAddr | input | 3 | Bus address |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data for busAddr |
| ovf0Flag | output | 1 | Timer 0 (or split low byte) overflow flag |
| ovf1Flag | output | 1 | Timer 1 (or split high byte) overflow flag |
| baudTick | output | 1 | One-cycle pulse per timer 1 overflow |

## Verification
Two pairs of functions can meet in one cycle. A bus write to a counter byte can land while that counter steps, and a software clear of a flag can land while an overflow sets it. Both are provoked with mode 2, an all-ones reload and the fast clock, so the timer overflows on every clock: bytes and flags are then written while steps and overflows keep arriving. A behavioural model in the bench decides each outcome from R12 and R13, and every cycle its result is compared with the read bus, the flags and the baud tick.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;

  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;

  typedef struct packed {
    logic stepT0;
    logic stepT1;
    logic stepTh0;
    logic split;
  } tmrStrobes_t;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              ovf;
  } tmrNext_t;

  // Next counter value for one step in the given mode.
  function automatic tmrNext_t advance(input logic [1:0] mode,
                                       input logic [BYTE_W-1:0] lo,
                                       input logic [BYTE_W-1:0] hi);
    tmrNext_t r;
    r.lo  = lo;
    r.hi  = hi;
    r.ovf = 1'b0;
    case (mode)
      2'd0: begin
        r.lo[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
        if (&lo[PRE_W-1:0]) begin
          r.hi  = hi + 1'b1;
          r.ovf = &hi;
        end
      end
      2'd1: begin
        {r.hi, r.lo} = {hi, lo} + 1'b1;
        r.ovf = &{hi, lo};
      end
      2'd2: begin
        r.lo  = (&lo) ? hi : lo + 1'b1;
        r.ovf = &lo;
      end
      default: begin
        r.lo  = lo + 1'b1;
        r.ovf = &lo;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dtmr_ctrl.sv
`timescale 1ns/1ps
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  extPin,
  input  logic [1:0]  gatePin,
  input  logic [1:0]  mode0,
  input  logic [1:0]  mode1,
  input  logic [1:0]  ctrSel,
  input  logic [1:0]  gateEn,
  input  logic [1:0]  run,
  input  logic [1:0]  fastClk,
  output tmrStrobes_t strobes
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int NPINS = 4;

  logic [PW-1:0]    preCnt;
  logic             slowTick;
  logic [NPINS-1:0] rawPins;
  logic [NPINS-1:0] pinSync;
  logic [1:0]       extPrev;
  logic [1:0]       extFall;
  logic [1:0]       timeBase;
  logic [1:0]       gateOk;
  logic             split;
  logic             t1Enable;
  logic             t1Source;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            preCnt <= '0;
    else if (preCnt == PW'(PRESCALE - 1)) preCnt <= '0;
    else                                  preCnt <= preCnt + 1'b1;
  end
  assign slowTick = (preCnt == PW'(PRESCALE - 1));

  assign rawPins = {gatePin, extPin};

  for (genvar p = 0; p < NPINS; p++) begin : gSync
    logic [SYNC_STAGES-1:0] shiftQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftQ <= '0;
      else       shiftQ <= {shiftQ[SYNC_STAGES-2:0], rawPins[p]};
    end
    assign pinSync[p] = shiftQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= '0;
    else       extPrev <= pinSync[1:0];
  end
  assign extFall = extPrev & ~pinSync[1:0];

  for (genvar t = 0; t < 2; t++) begin : gTimer
    assign timeBase[t] = fastClk[t] | slowTick;
    assign gateOk[t]   = ~gateEn[t] | pinSync[2 + t];
  end

  assign split    = (mode0 == 2'd3);
  assign t1Enable = (mode1 != 2'd3) & (split | (run[1] & gateOk[1]));
  assign t1Source = (ctrSel[1] & ~split) ? extFall[1] : timeBase[1];

  assign strobes.split   = split;
  assign strobes.stepT0  = run[0] & gateOk[0] & (ctrSel[0] ? extFall[0] : timeBase[0]);
  assign strobes.stepT1  = t1Enable & t1Source;
  assign strobes.stepTh0 = split & run[1] & timeBase[0];

endmodule

// File: rtl/dtmr_dp.sv
`timescale 1ns/1ps
module dtmr_dp
  import dtmr_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [1:0]        mode0,
  input  logic [1:0]        mode1,
  input  logic              busWe,
  input  logic [AW-1:0]     busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] tl0q,
  output logic [BYTE_W-1:0] th0q,
  output logic [BYTE_W-1:0] tl1q,
  output logic [BYTE_W-1:0] th1q,
  output logic              flag0q,
  output logic              flag1q,
  output logic              baudQ
);

  tmrNext_t n0, n1;
  logic wrTl0, wrTh0, wrTl1, wrTh1, wrFlags;
  logic t0Go, t1Go, th0Go;
  logic set0, set1, ovf1Evt;

  always_comb begin
    n0 = advance(mode0, tl0q, th0q);
    n1 = advance(mode1, tl1q, th1q);
  end

  assign wrTl0   = busWe & (busAddr == AW'(0));
  assign wrTh0   = busWe & (busAddr == AW'(1));
  assign wrTl1   = busWe & (busAddr == AW'(2));
  assign wrTh1   = busWe & (busAddr == AW'(3));
  assign wrFlags = busWe & (busAddr == AW'(4));

  // A write to either byte cancels the step, unless the bytes are split.
  assign t0Go    = strobes.stepT0 & ~wrTl0 & (strobes.split | ~wrTh0);
  assign th0Go   = strobes.stepTh0 & ~wrTh0;
  assign t1Go    = strobes.stepT1 & ~wrTl1 & ~wrTh1;
  assign ovf1Evt = t1Go & n1.ovf;
  assign set0    = t0Go & n0.ovf;
  assign set1    = (th0Go & (&th0q)) | (ovf1Evt & ~strobes.split);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tl0q <= '0;
      th0q <= '0;
    end else begin
      if (wrTl0)     tl0q <= busWdata;
      else if (t0Go) tl0q <= n0.lo;
      if (wrTh0)              th0q <= busWdata;
      else if (strobes.split) begin
        if (th0Go) th0q <= th0q + 1'b1;
      end else if (t0Go)      th0q <= n0.hi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tl1q <= '0;
      th1q <= '0;
    end else if (wrTl1 | wrTh1) begin
      if (wrTl1) tl1q <= busWdata;
      if (wrTh1) th1q <= busWdata;
    end else if (t1Go) begin
      tl1q <= n1.lo;
      th1q <= n1.hi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag0q <= 1'b0;
      flag1q <= 1'b0;
      baudQ  <= 1'b0;
    end else begin
      flag0q <= set0 | (wrFlags ? busWdata[0] : flag0q);
      flag1q <= set1 | (wrFlags ? busWdata[1] : flag1q);
      baudQ  <= ovf1Evt;
    end
  end

endmodule

// File: rtl/dual_timer.sv
`timescale 1ns/1ps
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extIn0,
  input  logic       extIn1,
  input  logic       gateIn0,
  input  logic       gateIn1,
  input  logic [1:0] mode0,
  input  logic       ctrSel0,
  input  logic       gateEn0,
  input  logic [1:0] mode1,
  input  logic       ctrSel1,
  input  logic       gateEn1,
  input  logic       run0,
  input  logic       run1,
  input  logic       fastClk0,
  input  logic       fastClk1,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       ovf0Flag,
  output logic       ovf1Flag,
  output logic       baudTick
);

  tmrStrobes_t strobes;
  logic [7:0]  tl0q, th0q, tl1q, th1q;

  dtmr_ctrl #(.PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .extPin  ({extIn1, extIn0}),
    .gatePin ({gateIn1, gateIn0}),
    .mode0   (mode0),
    .mode1   (mode1),
    .ctrSel  ({ctrSel1, ctrSel0}),
    .gateEn  ({gateEn1, gateEn0}),
    .run     ({run1, run0}),
    .fastClk ({fastClk1, fastClk0}),
    .strobes (strobes)
  );

  dtmr_dp #(.AW(3)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .mode0    (mode0),
    .mode1    (mode1),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .tl0q     (tl0q),
    .th0q     (th0q),
    .tl1q     (tl1q),
    .th1q     (th1q),
    .flag0q   (ovf0Flag),
    .flag1q   (ovf1Flag),
    .baudQ    (baudTick)
  );

  always_comb begin
    case (busAddr)
      3'd0:    busRdata = tl0q;
      3'd1:    busRdata = th0q;
      3'd2:    busRdata = tl1q;
      3'd3:    busRdata = th1q;
      3'd4:    busRdata = {6'b0, ovf1Flag, ovf0Flag};
      default: busRdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/dtmr_chk.sv
`timescale 1ns/1ps
module dtmr_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode0,
  input logic [1:0] mode1,
  input logic       run1,
  input logic       busWe,
  input logic [2:0] busAddr,
  input logic [7:0] busWdata,
  input logic [7:0] tl0q,
  input logic [7:0] th0q,
  input logic [7:0] tl1q,
  input logic [7:0] th1q,
  input logic       ovf0Flag,
  input logic       baudTick
);

  // R11: timer 1 parked in mode 3 keeps both bytes.
  p_t1_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode1 == 2'd3 && !busWe) |=> ($stable(tl1q) && $stable(th1q)));

  // R9: split high byte idles while timer 1's run bit is low.
  p_th0_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode0 == 2'd3 && !run1 && !busWe) |=> $stable(th0q));

  // R13: flag 0 falls only after a software write of 0.
  p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovf0Flag) |-> $past(busWe && busAddr == 3'd4 && !busWdata[0]));

  // R12: a byte write lands even while the counter steps.
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 3'd0) |=> (tl0q == $past(busWdata)));

  // R14: no baud tick after a cycle with timer 1 parked.
  p_baud_src_r14: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> ($past(mode1) != 2'd3));

endmodule

bind dual_timer dtmr_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .mode0    (mode0),
  .mode1    (mode1),
  .run1     (run1),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .tl0q     (tl0q),
  .th0q     (th0q),
  .tl1q     (tl1q),
  .th1q     (th1q),
  .ovf0Flag (ovf0Flag),
  .baudTick (baudTick)
);

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extIn0 = 1'b1, extIn1 = 1'b1, gateIn0 = 1'b0, gateIn1 = 1'b0;
  logic [1:0] mode0 = 2'd1, mode1 = 2'd1;
  logic       ctrSel0 = 1'b0, gateEn0 = 1'b0, ctrSel1 = 1'b0, gateEn1 = 1'b0;
  logic       run0 = 1'b0, run1 = 1'b0, fastClk0 = 1'b0, fastClk1 = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       ovf0Flag, ovf1Flag, baudTick;

  dual_timer uut (.*);

  always #2 clk = ~clk;

  int    vectors = 0;
  int    misses  = 0;
  bit    done    = 1'b0;
  string curReq  = "R1";

  // Behavioural reference model.
  int pre;
  int lo0, hi0, lo1, hi1;
  bit f0, f1, bd;
  bit sA[4], sB[4], prevE[2];

  function automatic bit modelStep(input int m, inout int lo, inout int hi);
    int v;
    bit o;
    o = 1'b0;
    if (m == 0) begin
      v = hi * 32 + (lo % 32) + 1;
      if (v == 8192) begin o = 1'b1; v = 0; end
      hi = v / 32;
      lo = (lo / 32) * 32 + (v % 32);
    end else if (m == 1) begin
      v = hi * 256 + lo + 1;
      if (v == 65536) begin o = 1'b1; v = 0; end
      hi = v / 256;
      lo = v % 256;
    end else begin
      if (lo == 255) begin o = 1'b1; lo = hi; end
      else lo = lo + 1;
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pre = 0; lo0 = 0; hi0 = 0; lo1 = 0; hi1 = 0; f0 = 0; f1 = 0; bd = 0;
      for (int i = 0; i < 4; i++) begin sA[i] = 0; sB[i] = 0; end
      prevE[0] = 0; prevE[1] = 0;
    end else begin
      bit slow, split, st0, st1, sth, en1, ov0, ov1, hSet;
      bit fall0, fall1, tb0, tb1;
      bit [4:0] wr;
      slow  = (pre == 11);
      tb0   = fastClk0 || slow;
      tb1   = fastClk1 || slow;
      fall0 = prevE[0] && !sB[0];
      fall1 = prevE[1] && !sB[1];
      split = (mode0 == 3);
      st0 = run0 && (!gateEn0 || sB[2]) && (ctrSel0 ? fall0 : tb0);
      en1 = (mode1 != 3) && (split || (run1 && (!gateEn1 || sB[3])));
      st1 = en1 && ((ctrSel1 && !split) ? fall1 : tb1);
      sth = split && run1 && tb0;
      for (int i = 0; i < 5; i++) wr[i] = busWe && (busAddr == i);
      ov0 = 0; ov1 = 0; hSet = 0;
      if (split) begin
        if (wr[0]) lo0 = busWdata;
        else if (st0) begin lo0 = (lo0 + 1) % 256; ov0 = (lo0 == 0); end
        if (wr[1]) hi0 = busWdata;
        else if (sth) begin hi0 = (hi0 + 1) % 256; hSet = (hi0 == 0); end
      end else begin
        if (wr[0] || wr[1]) begin
          if (wr[0]) lo0 = busWdata;
          if (wr[1]) hi0 = busWdata;
        end else if (st0) ov0 = modelStep(mode0, lo0, hi0);
      end
      if (wr[2] || wr[3]) begin
        if (wr[2]) lo1 = busWdata;
        if (wr[3]) hi1 = busWdata;
      end else if (st1) ov1 = modelStep(mode1, lo1, hi1);
      f0 = ov0 || (wr[4] ? busWdata[0] : f0);
      f1 = hSet || (ov1 && !split) || (wr[4] ? busWdata[1] : f1);
      bd = ov1;
      prevE[0] = sB[0]; prevE[1] = sB[1];
      for (int i = 0; i < 4; i++) sB[i] = sA[i];
      sA[0] = extIn0; sA[1] = extIn1; sA[2] = gateIn0; sA[3] = gateIn1;
      pre = (pre + 1) % 12;
    end
  end

  function automatic int expRead(input int a);
    case (a)
      0: return lo0;
      1: return hi0;
      2: return lo1;
      3: return hi1;
      4: return f1 * 2 + f0;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      int e;
      e = expRead(busAddr);
      vectors++;
      if (busRdata != e[7:0] || ovf0Flag != f0 || ovf1Flag != f1 || baudTick != bd) begin
        misses++;
        $display("FAIL %s: addr %0d rdata/f0/f1/baud = %02h/%0b/%0b/%0b, expected %02h/%0b/%0b/%0b",
                 curReq, busAddr, busRdata, ovf0Flag, ovf1Flag, baudTick, e[7:0], f0, f1, bd);
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (!busWe) busAddr = (busAddr >= 3'd4) ? 3'd0 : busAddr + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWe = 1'b0;
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic togglePin(input int which, input int count, input int hold);
    for (int k = 0; k < count; k++) begin
      if (which == 0) extIn0 = 1'b0; else extIn1 = 1'b0;
      tick(hold);
      if (which == 0) extIn0 = 1'b1; else extIn1 = 1'b1;
      tick(hold);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    #1;
    // R1: reset state at the ports.
    busAddr = 3'd0;
    for (int a = 0; a < 5; a++) begin
      busAddr = a[2:0]; #0.1;
      checkEq("R1", busRdata, 0);
    end
    checkEq("R1", baudTick, 0);

    // R2 / R6: 16-bit mode, fast vs divided timebase.
    curReq = "R2"; run0 = 1; run1 = 1; fastClk0 = 1; fastClk1 = 0;
    tick(300);
    curReq = "R6"; wr(3'd1, 8'hFF); wr(3'd0, 8'hF0);
    tick(40);
    wr(3'd4, 8'h00);

    // R5: 13-bit mode with prescale bits and untouched upper bits.
    curReq = "R5"; mode0 = 2'd0; wr(3'd1, 8'hFF); wr(3'd0, 8'hBB);
    tick(80);
    wr(3'd4, 8'h00);

    // R7 / R14: auto-reload on timer 1, baud ticks and flag 1.
    curReq = "R7"; mode1 = 2'd2; fastClk1 = 1; wr(3'd3, 8'hF8); wr(3'd2, 8'hF0);
    tick(60);
    curReq = "R14"; fastClk1 = 0; tick(300);
    wr(3'd4, 8'h00);

    // R3: external edges on timer 0 at several rates.
    curReq = "R3"; mode0 = 2'd1; ctrSel0 = 1; wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    togglePin(0, 10, 1);
    togglePin(0, 6, 3);
    togglePin(0, 4, 7);
    tick(6);

    // R4: gate pin qualifies the external count.
    curReq = "R4"; gateEn0 = 1; gateIn0 = 0;
    togglePin(0, 5, 2);
    gateIn0 = 1; togglePin(0, 5, 2);
    ctrSel0 = 0; fastClk0 = 1;
    for (int k = 0; k < 8; k++) begin gateIn0 = ~gateIn0; tick(5); end
    gateEn0 = 0; gateIn0 = 0; tick(20);

    // R8: split low byte with its own controls, flag 0.
    curReq = "R8"; mode0 = 2'd3; mode1 = 2'd1; wr(3'd0, 8'hF0); wr(3'd1, 8'h00);
    run1 = 0; tick(40);
    ctrSel0 = 1; togglePin(0, 6, 2); ctrSel0 = 0;
    wr(3'd4, 8'h00);

    // R9: split high byte follows run1, sets flag 1.
    curReq = "R9"; wr(3'd1, 8'hF8); run1 = 1; tick(30);
    run1 = 0; tick(20);
    fastClk0 = 0; run1 = 1; tick(150);
    wr(3'd4, 8'h00);

    // R10: timer 1 under split: ignores run/gate/counter, baud only.
    curReq = "R10"; run1 = 0; ctrSel1 = 1; gateEn1 = 1; gateIn1 = 0; fastClk1 = 1;
    wr(3'd3, 8'hFF); wr(3'd2, 8'hE0);
    togglePin(1, 10, 2);
    tick(40);
    checkEq("R10", ovf1Flag, 0);

    // R11: timer 1 parked in mode 3.
    curReq = "R11"; mode1 = 2'd3; wr(3'd2, 8'h5A);
    tick(50);
    busAddr = 3'd2; #0.1;
    checkEq("R11", busRdata, 8'h5A);
    mode1 = 2'd2; tick(30);

    // R12 / R13: writes colliding with steps and overflows.
    curReq = "R12"; mode0 = 2'd1; run0 = 1; fastClk0 = 1; ctrSel0 = 0;
    mode1 = 2'd2; ctrSel1 = 0; gateEn1 = 0; run1 = 1; fastClk1 = 1;
    wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
    for (int k = 0; k < 6; k++) begin wr(3'd0, 8'(k * 40)); wr(3'd1, 8'hFF); tick(1); end
    wr(3'd2, 8'h10); tick(3); wr(3'd2, 8'hFF);
    curReq = "R13"; wr(3'd4, 8'h00);
    #1; checkEq("R13", ovf1Flag, 1);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    tick(2);
    busAddr = 3'd5; #0.1;
    checkEq("R12", busRdata, 0);
    tick(20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule